// File: doc/BRIEF.md
# Downstream Port Power and Over-Current Controller

This block switches supply power for a set of external downstream hub ports and watches each port for an over-current fault. Every port has one open-drain control line with an external pull-up. The block holds the line low to keep the port unpowered and releases it to let the pull-up enable the power switch. While released, a switch that detects excess current pulls the same line low, and the block reads that level as a fault indication.

Host-side logic issues power-on, power-off and flag-acknowledge requests per port. Two delays are configured. One is an inrush window that runs after power-on; sensing is ignored during it, and its end marks the port as ready. The other is a filter that a low sense level must outlast before it counts as a fault. A fault removes power and latches a sticky change flag. Power comes back only after a new power-on request. In ganged mode all ports act as one: a request or a fault on any port applies to every port.

Top module: `ppc_port_power`

## Requirements
- R1: While reset is asserted, every control line is held low (`pin_pull_low` all ones) and `port_pwr`, `port_ready` and `oc_chg` are all zero.
- R2: An unpowered port that samples `req_pwr_on` high (and `req_pwr_off` low) on a clock edge has its control line released and `port_pwr` set after that edge, with `port_ready` still low.
- R3: `port_ready` rises exactly `cfg_on_dly`+1 clock edges after the edge that accepted the power-on request.
- R4: A low `pin_sense` level (low means over-current) during the inrush window, before `port_ready` rises, never causes a fault.
- R5: On a ready port, `pin_sense` sampled low on `cfg_oc_filt`+1 consecutive edges trips the port. On the last of those edges the line is pulled low, `port_pwr` and `port_ready` clear, and `oc_chg` for that port sets.
- R6: Any edge that samples `pin_sense` high restarts the filter count, so shorter low bursts never trip.
- R7: `oc_chg` stays set until an edge that samples `req_chg_ack` high for that port. A trip on the same edge as an acknowledge leaves the flag set. A tripped port stays unpowered until a new power-on request, which runs the full inrush window again.
- R8: `req_pwr_off` removes power from the port on the next edge without setting `oc_chg`. It overrides a simultaneous `req_pwr_on`.
- R9: With `cfg_ganged` low, requests and faults on one port leave every other port unchanged.
- R10: With `cfg_ganged` high, a power-on or power-off request on any port applies to all ports. A trip on any port unpowers all ports and sets every `oc_chg` bit. Acknowledges still clear flags per port.
- R11: A power-on request to a port that is already powered, including one still in its inrush window, has no effect and does not restart the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ganged | input | 1 | 1 = all ports switched and tripped together |
| cfg_on_dly | input | ON_W | Inrush window length minus one, in cycles |
| cfg_oc_filt | input | FILT_W | Over-current filter length minus one, in cycles |
| req_pwr_on | input | NPORT | Per-port power-on request |
| req_pwr_off | input | NPORT | Per-port power-off request |
| req_chg_ack | input | NPORT | Per-port change-flag acknowledge |
| pin_sense | input | NPORT | Level read back from each control line (0 = pulled low) |
| pin_pull_low | output | NPORT | 1 = drive the control line low (power off) |
| port_pwr | output | NPORT | Port power enabled (line released) |
| port_ready | output | NPORT | Inrush window elapsed, sensing armed |
| oc_chg | output | NPORT | Sticky over-current change flag |

## Verification
The checker assumes the two configuration delays and `cfg_ganged` change only while every port is unpowered. It also assumes requests start only after the internal reset synchronizer has released, and that `pin_sense` is already synchronous to `clk`. The stimulus changes the configuration only after a power-off of all ports. It waits several cycles after reset before the first request. It drives the sense lines from a model in which a pulled-low line always reads low and an injected fault pulls a released line low. Every input changes on the falling edge.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_RAMP = 2'd1,
    PS_ON   = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/ppc_rst_sync.sv
module ppc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ppc_oc_filter.sv
module ppc_oc_filter #(
  parameter int FILT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              sense_low,
  input  logic [FILT_W-1:0] filt_len,
  output logic              trip
);
  logic [FILT_W-1:0] cnt_q;
  logic              run;
  logic              hit;

  // count only while armed and the line reads low; a high sample restarts
  assign run  = arm & sense_low;
  assign hit  = run && (cnt_q == filt_len);
  assign trip = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || hit)  cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ppc_port_fsm.sv
module ppc_port_fsm
  import ppc_pkg::*;
#(
  parameter int ON_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            on_req,
  input  logic            off_req,
  input  logic            trip,
  input  logic            ack,
  input  logic [ON_W-1:0] on_dly,
  output logic            pwr,
  output logic            ready,
  output logic            chg
);
  pwr_state_e      st_q, st_d;
  logic [ON_W-1:0] cnt_q;
  logic            cnt_clr, cnt_inc;
  logic            chg_q, chg_d;

  always_comb begin
    st_d    = st_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (st_q)
      PS_OFF: begin
        if (on_req && !off_req && !trip) begin
          st_d    = PS_RAMP;
          cnt_clr = 1'b1;
        end
      end
      PS_RAMP: begin
        if (off_req || trip)        st_d = PS_OFF;
        else if (cnt_q == on_dly)   st_d = PS_ON;
        else                        cnt_inc = 1'b1;
      end
      PS_ON: begin
        if (off_req || trip) st_d = PS_OFF;
      end
      default: st_d = PS_OFF;
    endcase

    // a new fault outranks an acknowledge on the same edge
    chg_d = chg_q;
    if (trip)     chg_d = 1'b1;
    else if (ack) chg_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_OFF;
      chg_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      chg_q <= chg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_clr) cnt_q <= '0;
    else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
  end

  assign pwr   = (st_q != PS_OFF);
  assign ready = (st_q == PS_ON);
  assign chg   = chg_q;
endmodule

// File: rtl/ppc_port_power.sv
module ppc_port_power #(
  parameter int NPORT  = 2,
  parameter int ON_W   = 12,
  parameter int FILT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ganged,
  input  logic [ON_W-1:0]   cfg_on_dly,
  input  logic [FILT_W-1:0] cfg_oc_filt,
  input  logic [NPORT-1:0]  req_pwr_on,
  input  logic [NPORT-1:0]  req_pwr_off,
  input  logic [NPORT-1:0]  req_chg_ack,
  input  logic [NPORT-1:0]  pin_sense,
  output logic [NPORT-1:0]  pin_pull_low,
  output logic [NPORT-1:0]  port_pwr,
  output logic [NPORT-1:0]  port_ready,
  output logic [NPORT-1:0]  oc_chg
);
  logic             rst_int_n;
  logic [NPORT-1:0] trip_raw;
  logic [NPORT-1:0] on_eff, off_eff, trip_eff;
  logic             any_on, any_off, any_trip;

  ppc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign any_on   = |req_pwr_on;
  assign any_off  = |req_pwr_off;
  assign any_trip = |trip_raw;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    assign on_eff[i]   = cfg_ganged ? any_on   : req_pwr_on[i];
    assign off_eff[i]  = cfg_ganged ? any_off  : req_pwr_off[i];
    assign trip_eff[i] = cfg_ganged ? any_trip : trip_raw[i];

    ppc_oc_filter #(.FILT_W(FILT_W)) u_filt (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .arm       (port_ready[i]),
      .sense_low (~pin_sense[i]),
      .filt_len  (cfg_oc_filt),
      .trip      (trip_raw[i])
    );

    ppc_port_fsm #(.ON_W(ON_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .on_req  (on_eff[i]),
      .off_req (off_eff[i]),
      .trip    (trip_eff[i]),
      .ack     (req_chg_ack[i]),
      .on_dly  (cfg_on_dly),
      .pwr     (port_pwr[i]),
      .ready   (port_ready[i]),
      .chg     (oc_chg[i])
    );

    assign pin_pull_low[i] = ~port_pwr[i];
  end
endmodule

// File: rtl/ppc_port_power_chk.sv
module ppc_port_power_chk #(
  parameter int NPORT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_ganged,
  input logic [NPORT-1:0] req_pwr_on,
  input logic [NPORT-1:0] req_pwr_off,
  input logic [NPORT-1:0] req_chg_ack,
  input logic [NPORT-1:0] pin_sense,
  input logic [NPORT-1:0] port_pwr,
  input logic [NPORT-1:0] port_ready,
  input logic [NPORT-1:0] oc_chg
);
  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    AST_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_ganged && !port_pwr[i] && req_pwr_on[i] && !req_pwr_off[i]) |=> (port_pwr[i] && !port_ready[i])); // R2
    AST_READY_AFTER_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_ready[i]) |-> $past(port_pwr[i])); // R3
    AST_RAMP_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_ganged && port_pwr[i] && !port_ready[i]) |=> !$rose(oc_chg[i])); // R4
    AST_TRIP_UNPOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oc_chg[i]) |-> (!port_pwr[i] && !port_ready[i])); // R5
    AST_HIGH_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_ganged && pin_sense[i]) |=> !$rose(oc_chg[i])); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_chg[i] && !req_chg_ack[i]) |=> oc_chg[i]); // R7
    AST_OFF_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_ganged && req_pwr_off[i]) |=> !port_pwr[i]); // R8
  end

  AST_GANG_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ganged |-> ($countones(port_pwr) == 0 || $countones(port_pwr) == NPORT)); // R10
endmodule

bind ppc_port_power ppc_port_power_chk #(.NPORT(NPORT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_ganged  (cfg_ganged),
  .req_pwr_on  (req_pwr_on),
  .req_pwr_off (req_pwr_off),
  .req_chg_ack (req_chg_ack),
  .pin_sense   (pin_sense),
  .port_pwr    (port_pwr),
  .port_ready  (port_ready),
  .oc_chg      (oc_chg)
);

// File: tb/ppc_port_power_tb.sv
module ppc_port_power_tb;
  localparam int NP = 2;
  localparam int OW = 12;
  localparam int FW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_ganged;
  logic [OW-1:0] cfg_on_dly;
  logic [FW-1:0] cfg_oc_filt;
  logic [NP-1:0] req_pwr_on, req_pwr_off, req_chg_ack;
  logic [NP-1:0] pin_sense, oc_inj;
  logic [NP-1:0] pin_pull_low, port_pwr, port_ready, oc_chg;

  always #2 clk = ~clk;

  // line model: pulled low by the block, or by an injected switch fault
  assign pin_sense = ~pin_pull_low & ~oc_inj;

  ppc_port_power #(.NPORT(NP), .ON_W(OW), .FILT_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ganged(cfg_ganged),
    .cfg_on_dly(cfg_on_dly), .cfg_oc_filt(cfg_oc_filt),
    .req_pwr_on(req_pwr_on), .req_pwr_off(req_pwr_off), .req_chg_ack(req_chg_ack),
    .pin_sense(pin_sense), .pin_pull_low(pin_pull_low), .port_pwr(port_pwr),
    .port_ready(port_ready), .oc_chg(oc_chg)
  );

  typedef struct {
    int            at;
    string         tag;
    logic [NP-1:0] pwr;
    logic [NP-1:0] rdy;
    logic [NP-1:0] chg;
  } exp_t;

  exp_t sb[$];
  int   cyc   = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic want(int dt, string tag, logic [NP-1:0] p, logic [NP-1:0] r, logic [NP-1:0] c);
    exp_t e;
    e.at = cyc + dt; e.tag = tag; e.pwr = p; e.rdy = r; e.chg = c;
    sb.push_back(e);
  endtask

  task automatic tick(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic req(logic [NP-1:0] on, logic [NP-1:0] off, logic [NP-1:0] ack);
    req_pwr_on = on; req_pwr_off = off; req_chg_ack = ack;
    tick(1);
    req_pwr_on = '0; req_pwr_off = '0; req_chg_ack = '0;
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // monitor: pops scoreboard items due in this cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at == cyc) begin
          check({sb[i].tag, " pwr"}, port_pwr, sb[i].pwr);
          check({sb[i].tag, " line"}, pin_pull_low, ~sb[i].pwr);
          check({sb[i].tag, " ready"}, port_ready, sb[i].rdy);
          check({sb[i].tag, " flag"}, oc_chg, sb[i].chg);
          sb.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_ganged = 1'b0; cfg_on_dly = OW'(3); cfg_oc_filt = FW'(2);
    req_pwr_on = '0; req_pwr_off = '0; req_chg_ack = '0; oc_inj = '0;
    tick(3);
    check("R1 reset pwr", port_pwr, 2'b00);
    check("R1 reset line", pin_pull_low, 2'b11);
    check("R1 reset ready", port_ready, 2'b00);
    check("R1 reset flag", oc_chg, 2'b00);
    rst_n = 1'b1;
    tick(5);

    // R2 R3 R4: power port 0, fault on the line during inrush is ignored
    want(1, "R2 on", 2'b01, 2'b00, 2'b00);
    want(4, "R3 early", 2'b01, 2'b00, 2'b00);
    want(5, "R3 ready", 2'b01, 2'b01, 2'b00);
    req(2'b01, 2'b00, 2'b00);
    oc_inj = 2'b01;
    tick(3);
    oc_inj = 2'b00;
    want(1, "R4 inrush ignore", 2'b01, 2'b01, 2'b00);
    tick(3);

    // R5: three low samples trip port 0
    oc_inj = 2'b01;
    want(2, "R5 pending", 2'b01, 2'b01, 2'b00);
    want(3, "R5 trip", 2'b00, 2'b00, 2'b01);
    tick(3);
    oc_inj = 2'b00;
    tick(1);
    want(4, "R7 sticky", 2'b00, 2'b00, 2'b01);
    tick(5);
    want(1, "R7 ack", 2'b00, 2'b00, 2'b00);
    req(2'b00, 2'b00, 2'b01);
    tick(1);

    // R7 re-enable with full window, then R6 glitches
    want(5, "R7 reenable", 2'b01, 2'b01, 2'b00);
    req(2'b01, 2'b00, 2'b00);
    tick(5);
    oc_inj = 2'b01; tick(2);
    oc_inj = 2'b00; tick(1);
    oc_inj = 2'b01; tick(2);
    oc_inj = 2'b00;
    want(1, "R6 restart", 2'b01, 2'b01, 2'b00);
    tick(3);

    // R7: trip and acknowledge on the same edge
    oc_inj = 2'b01;
    tick(2);
    want(1, "R7 trip wins", 2'b00, 2'b00, 2'b01);
    req(2'b00, 2'b00, 2'b01);
    oc_inj = 2'b00;
    tick(1);
    want(1, "R7 ack2", 2'b00, 2'b00, 2'b00);
    req(2'b00, 2'b00, 2'b01);

    // R8: off request, and off beats on
    want(1, "R9 port1 on", 2'b10, 2'b00, 2'b00);
    req(2'b10, 2'b00, 2'b00);
    want(1, "R8 off", 2'b00, 2'b00, 2'b00);
    req(2'b00, 2'b10, 2'b00);
    want(1, "R8 off wins", 2'b00, 2'b00, 2'b00);
    req(2'b10, 2'b10, 2'b00);
    tick(2);

    // R9: port 1 trips alone
    want(1, "R9 both on", 2'b11, 2'b00, 2'b00);
    req(2'b11, 2'b00, 2'b00);
    tick(5);
    oc_inj = 2'b10;
    want(3, "R9 own trip", 2'b01, 2'b01, 2'b10);
    tick(3);
    oc_inj = 2'b00;
    want(1, "R8 all off", 2'b00, 2'b00, 2'b00);
    req(2'b00, 2'b11, 2'b10);
    tick(1);

    // R11: repeat request during inrush does not restart it
    want(1, "R11 on", 2'b01, 2'b00, 2'b00);
    want(4, "R11 not early", 2'b01, 2'b00, 2'b00);
    want(5, "R11 ready", 2'b01, 2'b01, 2'b00);
    req(2'b01, 2'b00, 2'b00);
    tick(1);
    req(2'b01, 2'b00, 2'b00);
    tick(3);
    want(1, "R8 off2", 2'b00, 2'b00, 2'b00);
    req(2'b00, 2'b01, 2'b00);
    tick(1);

    // R10: ganged operation
    cfg_ganged = 1'b1;
    tick(1);
    want(1, "R10 gang on", 2'b11, 2'b00, 2'b00);
    want(5, "R10 gang ready", 2'b11, 2'b11, 2'b00);
    req(2'b10, 2'b00, 2'b00);
    tick(5);
    oc_inj = 2'b10;
    want(3, "R10 gang trip", 2'b00, 2'b00, 2'b11);
    tick(3);
    oc_inj = 2'b00;
    want(1, "R10 ack one", 2'b00, 2'b00, 2'b10);
    req(2'b00, 2'b00, 2'b01);
    want(1, "R10 ack other", 2'b00, 2'b00, 2'b00);
    req(2'b00, 2'b00, 2'b10);
    want(1, "R10 gang on2", 2'b11, 2'b00, 2'b00);
    req(2'b01, 2'b00, 2'b00);
    want(1, "R10 gang off", 2'b00, 2'b00, 2'b00);
    req(2'b00, 2'b10, 2'b00);
    tick(3);

    if (sb.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R1 scoreboard act=%0d exp=0 items left", sb.size());
    end
    done = 1'b1;
    report();
    $finish;
  end
endmodule